// File: doc/BRIEF.md
# Framed Command Block Checker

This block sits between a byte-level link receiver and a command execution engine. It takes in one command block at a time as a stream of bytes. The first byte of the block is a length count. Packet bytes follow it, and a two-byte CRC-16 closes the block. Before anything is passed on, the checker confirms three things: the count is legal, the CRC matches, and the block size is the one the opcode requires.

When a block is good, the checker splits its packet into fields: an opcode, an 8-bit first parameter, a 16-bit second parameter and a data area. It then raises a one-cycle done pulse. When a block is bad, it raises a one-cycle error pulse with a one-byte response code instead. One code covers link faults (a bad count or a CRC mismatch). The other code covers a command that is well delivered but malformed (an unknown opcode or the wrong size).

Bytes arrive over a valid/ready handshake. A start-of-block strobe travels with the count byte. That strobe also lets the sender abandon a partial block at any point and start again.

Top module: `cmd_block_checker`

## Requirements
- R1: After reset, `in_ready` is 1 and both `cmd_done` and `err_valid` are 0.
- R2: A count byte (accepted with `in_sob`=1) below 4 or above 39 produces `err_valid` with `err_code` 0xFF. The bytes without `in_sob` that follow it are ignored and produce no output.
- R3: The CRC register starts at zero and uses polynomial 0x8005. It takes each byte least significant bit first: the feedback is the input bit XOR crc[15], the register shifts left, and it XORs in 0x8005 when the feedback is 1. The CRC covers the count byte and the packet bytes. In the block, the CRC's low byte comes first and its high byte is the final byte. A mismatch produces `err_code` 0xFF.
- R4: When a block has both a CRC mismatch and a format fault, the reported code is 0xFF.
- R5: The supported opcodes and their required total block sizes are: 0x05 needs 7, 0x0A needs 11, 0x08 needs 39, and 0x11 needs 4. Any other opcode in a block with a correct CRC produces `err_code` 0x0F.
- R6: A supported opcode in a block with a correct CRC but a count different from its required size produces `err_code` 0x0F.
- R7: On `cmd_done`, the fields map as follows: `cmd_opcode` is packet byte 0, `cmd_param1` is packet byte 1, `cmd_param2[7:0]` is packet byte 2 and `cmd_param2[15:8]` is packet byte 3. Any field the block is too short to carry reads as zero.
- R8: Packet byte 4+k appears at `cmd_data[8k+7:8k]`. `cmd_data_len` equals count−7 when the count is 7 or more, and 0 otherwise. Unfilled data bytes read as zero.
- R9: If the last byte of a block is accepted at clock edge E, `in_ready` is 0 during the cycle after E, and the result pulse is visible during the cycle after edge E+1.
- R10: Bytes offered with `in_sob`=0 while no block is open are consumed and produce no output.
- R11: A byte with `in_sob`=1 in mid-block discards the open block without any result and becomes the count byte of a new block.
- R12: `cmd_done` and `err_valid` are never high together, and each one stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Checker can accept a byte |
| in_sob | input | 1 | Marks the count byte that opens a block |
| in_data | input | 8 | Input byte |
| cmd_done | output | 1 | One-cycle pulse: block accepted, fields valid |
| cmd_opcode | output | 8 | Opcode field |
| cmd_param1 | output | 8 | First parameter |
| cmd_param2 | output | 16 | Second parameter, little-endian |
| cmd_data | output | 256 | Data bytes, byte k at bits [8k+7:8k] |
| cmd_data_len | output | 6 | Number of valid data bytes |
| err_valid | output | 1 | One-cycle pulse: block rejected |
| err_code | output | 8 | 0xFF link fault, 0x0F format fault |

## Verification
A byte position counter that is off by one would shift every field and would read the CRC from the wrong bytes. That shows up at the ports within one block, as a wrong field value or a false 0xFF. A CRC register that is stale or not cleared turns the next good block into an error. This is why good blocks are sent one after another, and why a good block follows every aborted or rejected one. A state machine stuck outside idle shows up as `in_ready` staying low, or as a result pulse that arrives too early, too late or never. Because of this, the cycle of every pulse is checked exactly against the acceptance of the last byte.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_EVAL = 2'd2
  } cbc_state_e;

  localparam logic [7:0] ERR_LINK   = 8'hFF;
  localparam logic [7:0] ERR_FORMAT = 8'h0F;

  // One byte through the CRC register, least significant input bit first.
  function automatic logic [15:0] crc_step_byte(input logic [15:0] crc_in,
                                                input logic [7:0]  din,
                                                input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      fb = din[b] ^ c[15];
      c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return c;
  endfunction

  // Required total block size per opcode, 0 when the opcode is unsupported.
  function automatic logic [7:0] op_block_size(input logic [7:0] op);
    case (op)
      8'h05:   return 8'd7;
      8'h0A:   return 8'd11;
      8'h08:   return 8'd39;
      8'h11:   return 8'd4;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/cbc_crc16.sv
module cbc_crc16 #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import cbc_pkg::*;

  logic [15:0] crc_q, crc_d, base;

  always_comb begin
    base  = clr ? 16'h0000 : crc_q;
    crc_d = en ? crc_step_byte(base, din, POLY) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 16'h0000;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  p_crc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(crc_q));

  p_crc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (crc_q == 16'h0000));

endmodule

// File: rtl/cbc_op_size.sv
module cbc_op_size (
  input  logic [7:0] opcode,
  output logic [7:0] req_size,
  output logic       known
);
  import cbc_pkg::*;

  always_comb begin
    req_size = op_block_size(opcode);
    known    = (req_size != 8'd0);
  end

endmodule

// File: rtl/cbc_data_buf.sv
module cbc_data_buf #(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  output logic [DEPTH*8-1:0] data_flat
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [7:0] slot_q, slot_d;
    logic       hit;

    always_comb begin
      hit    = wr_en && (wr_idx == AW'(k));
      slot_d = clr ? 8'h00 : (hit ? wr_data : slot_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= 8'h00;
      else        slot_q <= slot_d;
    end

    assign data_flat[8*k +: 8] = slot_q;
  end

  p_wr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < DEPTH));

  p_no_write_on_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr));

endmodule

// File: rtl/cmd_block_checker.sv
module cmd_block_checker #(
  parameter int MIN_BLOCK = 4,
  parameter int MAX_BLOCK = 39,
  localparam int DATA_MAX = MAX_BLOCK - 7,
  localparam int DAW      = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1,
  localparam int LENW     = $clog2(DATA_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_sob,
  input  logic [7:0]            in_data,
  output logic                  cmd_done,
  output logic [7:0]            cmd_opcode,
  output logic [7:0]            cmd_param1,
  output logic [15:0]           cmd_param2,
  output logic [DATA_MAX*8-1:0] cmd_data,
  output logic [LENW-1:0]       cmd_data_len,
  output logic                  err_valid,
  output logic [7:0]            err_code
);
  import cbc_pkg::*;

  // ---------------- state registers ----------------
  cbc_state_e      state_q, state_d;
  logic [7:0]      pos_q, pos_d;        // position of next byte in block
  logic [7:0]      count_q, count_d;
  logic            badcnt_q, badcnt_d;
  logic [7:0]      op_q, op_d;
  logic [7:0]      p1_q, p1_d;
  logic [15:0]     p2_q, p2_d;
  logic [7:0]      rcrc_lo_q, rcrc_lo_d;
  logic [7:0]      rcrc_hi_q, rcrc_hi_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic [7:0]      code_q, code_d;
  logic [LENW-1:0] len_q, len_d;

  // ---------------- sub-block wiring ----------------
  logic            crc_clr, crc_en;
  logic [15:0]     crc_val;
  logic [7:0]      req_size;
  logic            op_known;
  logic            buf_clr, buf_wr;
  logic [DAW-1:0]  buf_idx;

  logic            accept, start;
  logic            count_ok;
  logic            crc_match;
  logic [7:0]      last_pkt_pos;

  assign in_ready = (state_q != ST_EVAL);
  assign accept   = in_valid && in_ready;
  assign start    = accept && in_sob;
  assign count_ok = (in_data >= 8'(MIN_BLOCK)) && (in_data <= 8'(MAX_BLOCK));
  assign crc_match    = ({rcrc_hi_q, rcrc_lo_q} == crc_val);
  assign last_pkt_pos = count_q - 8'd3;

  cbc_crc16 #(.POLY(16'h8005)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc_val)
  );

  cbc_op_size u_size (
    .opcode   (op_q),
    .req_size (req_size),
    .known    (op_known)
  );

  cbc_data_buf #(.DEPTH(DATA_MAX)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (buf_clr),
    .wr_en     (buf_wr),
    .wr_idx    (buf_idx),
    .wr_data   (in_data),
    .data_flat (cmd_data)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d   = state_q;
    pos_d     = pos_q;
    count_d   = count_q;
    badcnt_d  = badcnt_q;
    op_d      = op_q;
    p1_d      = p1_q;
    p2_d      = p2_q;
    rcrc_lo_d = rcrc_lo_q;
    rcrc_hi_d = rcrc_hi_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    code_d    = code_q;
    len_d     = len_q;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    buf_idx   = '0;

    if (start) begin
      // count byte opens a block; any open block is dropped
      count_d   = in_data;
      pos_d     = 8'd1;
      op_d      = 8'h00;
      p1_d      = 8'h00;
      p2_d      = 16'h0000;
      rcrc_lo_d = 8'h00;
      rcrc_hi_d = 8'h00;
      buf_clr   = 1'b1;
      crc_clr   = 1'b1;
      crc_en    = count_ok;
      badcnt_d  = !count_ok;
      state_d   = count_ok ? ST_RECV : ST_EVAL;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // stray bytes are consumed and dropped
        end
        ST_RECV: begin
          if (accept) begin
            pos_d = pos_q + 8'd1;
            if (pos_q <= last_pkt_pos) begin
              crc_en = 1'b1;
              unique case (pos_q)
                8'd1:    op_d       = in_data;
                8'd2:    p1_d       = in_data;
                8'd3:    p2_d[7:0]  = in_data;
                8'd4:    p2_d[15:8] = in_data;
                default: begin
                  buf_wr  = 1'b1;
                  buf_idx = DAW'(pos_q - 8'd5);
                end
              endcase
            end else if (pos_q == count_q - 8'd2) begin
              rcrc_lo_d = in_data;
            end else begin
              rcrc_hi_d = in_data;
              state_d   = ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          state_d = ST_IDLE;
          if (badcnt_q || !crc_match) begin
            err_d  = 1'b1;
            code_d = ERR_LINK;
          end else if (!op_known || (req_size != count_q)) begin
            err_d  = 1'b1;
            code_d = ERR_FORMAT;
          end else begin
            done_d = 1'b1;
            len_d  = (count_q >= 8'd7) ? LENW'(count_q - 8'd7) : '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pos_q     <= 8'd0;
      count_q   <= 8'd0;
      badcnt_q  <= 1'b0;
      op_q      <= 8'h00;
      p1_q      <= 8'h00;
      p2_q      <= 16'h0000;
      rcrc_lo_q <= 8'h00;
      rcrc_hi_q <= 8'h00;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= 8'h00;
      len_q     <= '0;
    end else begin
      state_q   <= state_d;
      pos_q     <= pos_d;
      count_q   <= count_d;
      badcnt_q  <= badcnt_d;
      op_q      <= op_d;
      p1_q      <= p1_d;
      p2_q      <= p2_d;
      rcrc_lo_q <= rcrc_lo_d;
      rcrc_hi_q <= rcrc_hi_d;
      done_q    <= done_d;
      err_q     <= err_d;
      code_q    <= code_d;
      len_q     <= len_d;
    end
  end

  assign cmd_done     = done_q;
  assign err_valid    = err_q;
  assign err_code     = code_q;
  assign cmd_opcode   = op_q;
  assign cmd_param1   = p1_q;
  assign cmd_param2   = p2_q;
  assign cmd_data_len = len_q;

  // ---------------- assertions ----------------
  p_result_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && err_valid));

  p_result_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done || err_valid) |=> !(cmd_done || err_valid));

  p_result_after_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done || err_valid) |-> $past(state_q == ST_EVAL));

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ((err_code == ERR_LINK) || (err_code == ERR_FORMAT)));

  p_done_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (op_block_size(cmd_opcode) == count_q));

  p_pos_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV) |-> (pos_q < count_q) && (count_q <= 8'(MAX_BLOCK)));

endmodule

// File: tb/cmd_block_checker_bench.sv
module cmd_block_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DMAX = 32;

  logic            clk, rst_n;
  logic            in_valid, in_ready, in_sob;
  logic [7:0]      in_data;
  logic            cmd_done, err_valid;
  logic [7:0]      cmd_opcode, cmd_param1, err_code;
  logic [15:0]     cmd_param2;
  logic [DMAX*8-1:0] cmd_data;
  logic [5:0]      cmd_data_len;

  cmd_block_checker u_cmd_block_checker (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob), .in_data(in_data),
    .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .cmd_param1(cmd_param1),
    .cmd_param2(cmd_param2), .cmd_data(cmd_data), .cmd_data_len(cmd_data_len),
    .err_valid(err_valid), .err_code(err_code)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_done  = 0;
  int n_err   = 0;
  logic [7:0] fr [0:63];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_done) n_done++;
      if (err_valid) n_err++;
      if (cmd_done && err_valid) begin
        n_fail++;
        $display("FAIL R12: done and error together act=11 exp=not both");
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic f;
        f = fr[i][b] ^ c[15];
        c = c << 1;
        if (f) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic build(input logic [7:0] op, input logic [7:0] p1,
                       input logic [15:0] p2, input int cnt, input logic [7:0] corrupt);
    logic [15:0] c;
    fr[0] = 8'(cnt);
    for (int i = 1; i <= cnt - 3; i++) begin
      case (i)
        1: fr[i] = op;
        2: fr[i] = p1;
        3: fr[i] = p2[7:0];
        4: fr[i] = p2[15:8];
        default: fr[i] = 8'((i - 5) * 7) + op;
      endcase
    end
    c = ref_crc(cnt - 2);
    fr[cnt-2] = c[7:0] ^ corrupt;
    fr[cnt-1] = c[15:8];
  endtask

  task automatic push(input logic [7:0] b, input logic sob);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_sob   = sob;
    @(posedge clk);
  endtask

  task automatic send(input int first, input int n);
    for (int i = first; i < first + n; i++) push(fr[i], i == 0);
  endtask

  // after last byte edge: cycle between is quiet with ready low, pulse next
  task automatic finish_block(input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_sob = 1'b0;
    chk(!cmd_done && !err_valid && !in_ready, {tag, " R9 early"},
        {29'd0, cmd_done, err_valid, in_ready}, 32'd0);
    @(negedge clk);
  endtask

  task automatic expect_done(input string tag, input logic [7:0] op, input logic [7:0] p1,
                             input logic [15:0] p2, input int len);
    int d0 = n_done;
    finish_block(tag);
    chk(cmd_done && !err_valid, {tag, " R9 done pulse"}, {30'd0, cmd_done, err_valid}, 32'd2);
    chk(cmd_opcode == op && cmd_param1 == p1, {tag, " R7 op/p1"},
        {16'd0, cmd_opcode, cmd_param1}, {16'd0, op, p1});
    chk(cmd_param2 == p2, {tag, " R7 p2"}, 32'(cmd_param2), 32'(p2));
    chk(int'(cmd_data_len) == len, {tag, " R8 len"}, 32'(cmd_data_len), 32'(len));
    for (int k = 0; k < DMAX; k++) begin
      logic [7:0] e = (k < len) ? 8'(k * 7) + op : 8'h00;
      if (cmd_data[8*k +: 8] != e) chk(1'b0, {tag, " R8 data"}, 32'(cmd_data[8*k +: 8]), 32'(e));
    end
    @(negedge clk);
    chk(!cmd_done && (n_done == d0 + 1), {tag, " R12 single"}, 32'(n_done - d0), 32'd1);
  endtask

  task automatic expect_err(input string tag, input logic [7:0] code);
    finish_block(tag);
    chk(err_valid && !cmd_done && err_code == code, tag, {23'd0, err_valid, err_code}, {23'd1, code});
    @(negedge clk);
    chk(!err_valid, {tag, " R12 single"}, 32'(err_valid), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready && !cmd_done && !err_valid, "R1 reset",
        {29'd0, in_ready, cmd_done, err_valid}, 32'd4);
  endtask

  task automatic t_good;
    build(8'h05, 8'h3C, 16'hA15B, 7, 8'h00); send(0, 7); expect_done("R7 op05", 8'h05, 8'h3C, 16'hA15B, 0);
    build(8'h0A, 8'h01, 16'h0203, 11, 8'h00); send(0, 11); expect_done("R8 op0A", 8'h0A, 8'h01, 16'h0203, 4);
    build(8'h08, 8'hFE, 16'hFFFF, 39, 8'h00); send(0, 39); expect_done("R5 op08 max", 8'h08, 8'hFE, 16'hFFFF, 32);
    build(8'h11, 8'h00, 16'h0000, 4, 8'h00); send(0, 4); expect_done("R5 op11 min", 8'h11, 8'h00, 16'h0000, 0);
  endtask

  task automatic t_crc_bad;
    build(8'h05, 8'h10, 16'h1234, 7, 8'h01); send(0, 7); expect_err("R3 crc low byte", 8'hFF);
    build(8'h05, 8'h10, 16'h1234, 7, 8'h00); fr[6] = fr[6] ^ 8'h80; send(0, 7); expect_err("R3 crc high byte", 8'hFF);
    build(8'h77, 8'h10, 16'h1234, 9, 8'h20); send(0, 9); expect_err("R4 crc over format", 8'hFF);
  endtask

  task automatic t_format;
    build(8'h77, 8'h00, 16'h0000, 7, 8'h00); send(0, 7); expect_err("R5 unknown op", 8'h0F);
    build(8'h0A, 8'h00, 16'h0000, 7, 8'h00); send(0, 7); expect_err("R6 size mismatch", 8'h0F);
  endtask

  task automatic t_count(input int cnt);
    int d0, e0;
    fr[0] = 8'(cnt);
    push(fr[0], 1'b1);
    expect_err("R2 count range", 8'hFF);
    d0 = n_done; e0 = n_err;
    for (int i = 0; i < 5; i++) push(8'(i + 4), 1'b0);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_done == d0 && n_err == e0, "R2 tail ignored", 32'(n_done + n_err), 32'(d0 + e0));
  endtask

  task automatic t_stray;
    int d0 = n_done, e0 = n_err;
    push(8'h07, 1'b0); push(8'h05, 1'b0); push(8'h00, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_done == d0 && n_err == e0, "R10 stray bytes", 32'(n_done + n_err), 32'(d0 + e0));
    build(8'h05, 8'h44, 16'h5566, 7, 8'h00); send(0, 7); expect_done("R10 after stray", 8'h05, 8'h44, 16'h5566, 0);
  endtask

  task automatic t_abort;
    int e0 = n_err;
    build(8'h0A, 8'h99, 16'h8888, 11, 8'h00); send(0, 6);
    build(8'h05, 8'h21, 16'h4321, 7, 8'h00); send(0, 7);
    expect_done("R11 abort restart", 8'h05, 8'h21, 16'h4321, 0);
    chk(n_err == e0, "R11 no result for aborted", 32'(n_err), 32'(e0));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_good();
    t_crc_bad();
    t_format();
    t_count(3);
    t_count(40);
    t_stray();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule